// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block is the interrupt logic of an eight-input interrupt board that sits on a serial priority chain. Each of the eight inputs feeds its own cell. A rising edge on an input latches a pending flag, so a short pulse is kept until it is serviced. Priority enters the board at the first cell and runs through the cells one after another. A cell that holds priority and has an interrupt pending stops priority from going further and raises the shared request. A cell with nothing pending passes priority straight on.

When the processor acknowledges, only the cell that holds the chain drives its vector byte onto the data bus, and its pending flag clears at the next clock edge. Each input's vector is `VEC_BASE + index * VEC_STRIDE`. The board's priority output feeds the next controller downstream. Its request output joins the OR of the single request line that every controller on the bus shares. The processor's dispatch on the vector is outside this block.

Top module: `irq_chain_board`

## Requirements
- R1: After reset no input is pending, `req_o` and `vec_oe_o` are 0, `vec_o` is 0, and `pri_o` equals `pri_i`.
- R2: A 0-to-1 change on `irq_i[k]` makes input k pending at the next clock edge. An input held high after it has been serviced does not become pending again.
- R3: While `pri_i` is 1 and any input is pending, `req_o` is 1. Among the pending inputs, the one with the lowest index wins, because index 0 is nearest to `pri_i`.
- R4: `pri_o` is 1 only when `pri_i` is 1 and no input is pending. When `pri_i` is 0, `req_o` is 0.
- R5: In a cycle where `ack_i` and `req_o` are both 1, `vec_oe_o` is 1 and `vec_o` equals `VEC_BASE + k*VEC_STRIDE` for the winning input k (defaults 0x40 and 4), in that same cycle.
- R6: An acknowledged input stops being pending at the next clock edge. All other pending inputs stay pending.
- R7: When `ack_i` is 1 while `req_o` is 0, `vec_oe_o` stays 0, `vec_o` stays 0, and no pending state changes.
- R8: A one-cycle pulse that arrives while `pri_i` is 0 stays pending until priority returns and the input is acknowledged.
- R9: If a new rising edge on an input arrives in the same cycle that the input is acknowledged, the input stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_SRC | External interrupt inputs, edge-sensitive |
| pri_i | input | 1 | Priority from the upstream controller |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| pri_o | output | 1 | Priority to the downstream controller |
| req_o | output | 1 | This board's part of the shared request |
| vec_o | output | VEC_W | Vector byte, 0 when not driven |
| vec_oe_o | output | 1 | Vector drive enable |

## Verification
The bench sets every non-empty combination of the eight inputs and acknowledges repeatedly. The vectors must come out in ascending index order, and the request must drop after the last one. A design that let a lower cell lose to a higher one, or that cleared more than the winner, would produce a different sequence. Further tests cover three cases. The first is a level input held high after service, which a design that wrongly detects levels would re-raise. The second is a pulse that arrives while upstream priority is withheld, which a design without latching would lose. The third is an edge that coincides with its own acknowledge, which a design that gives clear precedence over set would drop. An acknowledge with nothing pending must leave the bus quiet.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int unsigned DEF_VEC_W = 8;

  function automatic int unsigned vec_calc(input int unsigned base,
                                           input int unsigned stride,
                                           input int unsigned idx);
    return base + idx * stride;
  endfunction
endpackage

// File: rtl/irq_edge_pend.sv
module irq_edge_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic clr_i,
  output logic pend_o
);
  logic irq_q, rise, pend_q;

  assign rise = irq_i & ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      irq_q <= irq_i;
      // a fresh edge wins over a clear in the same cycle
      if (rise)       pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_chain_cell.sv
module irq_chain_cell #(
  parameter int unsigned          VEC_W = 8,
  parameter logic [VEC_W-1:0]     VEC   = '0
) (
  input  logic             pri_i,
  input  logic             pend_i,
  input  logic             ack_i,
  output logic             pri_o,
  output logic             req_o,
  output logic             clr_o,
  output logic [VEC_W-1:0] vec_o
);
  logic hold;

  assign hold  = pri_i & pend_i;
  assign pri_o = pri_i & ~pend_i;
  assign req_o = hold;
  assign clr_o = hold & ack_i;
  assign vec_o = clr_o ? VEC : '0;
endmodule

// File: rtl/irq_chain_board.sv
module irq_chain_board
  import irq_chain_pkg::*;
#(
  parameter int unsigned N_SRC      = 8,
  parameter int unsigned VEC_W      = DEF_VEC_W,
  parameter int unsigned VEC_BASE   = 'h40,
  parameter int unsigned VEC_STRIDE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             pri_i,
  input  logic             ack_i,
  output logic             pri_o,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_oe_o
);
  logic [N_SRC:0]   chain;
  logic [N_SRC-1:0] pend, req_v, clr_v;
  logic [VEC_W-1:0] cell_vec [N_SRC];

  assign chain[0] = pri_i;

  for (genvar i = 0; i < N_SRC; i++) begin : g_cell
    localparam logic [VEC_W-1:0] CELL_VEC =
      VEC_W'(vec_calc(VEC_BASE, VEC_STRIDE, i));

    irq_edge_pend u_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .irq_i  (irq_i[i]),
      .clr_i  (clr_v[i]),
      .pend_o (pend[i])
    );

    irq_chain_cell #(.VEC_W(VEC_W), .VEC(CELL_VEC)) u_cell (
      .pri_i  (chain[i]),
      .pend_i (pend[i]),
      .ack_i  (ack_i),
      .pri_o  (chain[i+1]),
      .req_o  (req_v[i]),
      .clr_o  (clr_v[i]),
      .vec_o  (cell_vec[i])
    );
  end

  // wired-OR of the cell drivers; at most one is enabled
  always_comb begin
    vec_o = '0;
    for (int i = 0; i < N_SRC; i++) vec_o |= cell_vec[i];
  end

  assign pri_o    = chain[N_SRC];
  assign req_o    = |req_v;
  assign vec_oe_o = |clr_v;
endmodule

// File: rtl/irq_chain_board_chk.sv
module irq_chain_board_chk #(
  parameter int unsigned VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pri_i,
  input logic             ack_i,
  input logic             pri_o,
  input logic             req_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_oe_o
);
  p_no_req_without_pri_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pri_i |-> !req_o);

  p_pri_passes_only_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_o |-> (pri_i && !req_o));

  p_idle_passes_pri_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_i && !req_o) |-> pri_o);

  p_oe_on_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o == (ack_i && req_o));

  p_bus_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_oe_o |-> (vec_o == '0));
endmodule

bind irq_chain_board irq_chain_board_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pri_i    (pri_i),
  .ack_i    (ack_i),
  .pri_o    (pri_o),
  .req_o    (req_o),
  .vec_o    (vec_o),
  .vec_oe_o (vec_oe_o)
);

// File: tb/tb_irq_chain_board.sv
`timescale 1ns/1ps
module tb_irq_chain_board;
  localparam int N = 8;
  localparam int BASE = 'h40;
  localparam int STRIDE = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] irq_i = '0;
  logic pri_i = 1'b1, ack_i = 1'b0;
  logic pri_o, req_o, vec_oe_o;
  logic [7:0] vec_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  irq_chain_board dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .pri_i(pri_i),
    .ack_i(ack_i), .pri_o(pri_o), .req_o(req_o), .vec_o(vec_o),
    .vec_oe_o(vec_oe_o)
  );

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int vec_of(input int k);
    return (BASE + k * STRIDE) & 'hff;
  endfunction

  task automatic pulse(input logic [N-1:0] m);
    irq_i = m; tick(); irq_i = '0; tick();
  endtask

  // acknowledge once, check vector, let the clear land
  task automatic ack_expect(input string req, input int k);
    ack_i = 1'b1; #0.5;
    chk(req, vec_oe_o, 1);
    chk(req, vec_o, vec_of(k));
    tick(); ack_i = 1'b0; #0.5;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #12 rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk("R1 req", req_o, 0);
    chk("R1 oe", vec_oe_o, 0);
    chk("R1 vec", vec_o, 0);
    chk("R1 pri_o", pri_o, 1);

    // R7 ack with nothing pending
    ack_i = 1'b1; #0.5;
    chk("R7 oe", vec_oe_o, 0);
    chk("R7 vec", vec_o, 0);
    tick(); ack_i = 1'b0; #0.5;
    chk("R7 req", req_o, 0);
    chk("R7 pri_o", pri_o, 1);

    // R3 R5 R6: sweep every non-empty mask, service in ascending order
    for (int m = 1; m < (1 << N); m++) begin
      pulse(N'(m));
      chk("R3 req", req_o, 1);
      chk("R4 pri_o blocked", pri_o, 0);
      for (int k = 0; k < N; k++) begin
        if (m[k]) begin
          chk("R3 req held", req_o, 1);
          ack_expect("R5 vector", k);
        end
      end
      chk("R6 all cleared", req_o, 0);
      chk("R6 pri_o restored", pri_o, 1);
    end

    // R4 priority withheld
    pulse(8'h04);
    pri_i = 1'b0; #0.5;
    chk("R4 req no pri", req_o, 0);
    chk("R4 pri_o no pri", pri_o, 0);
    pri_i = 1'b1; #0.5;
    ack_expect("R4 vector after", 2);

    // R2 level held stays serviced
    irq_i = 8'h08; tick();
    chk("R2 pending", req_o, 1);
    ack_expect("R2 vector", 3);
    tick(); tick();
    chk("R2 no retrigger", req_o, 0);
    irq_i = '0; tick();

    // R8 pulse while blocked
    pri_i = 1'b0;
    pulse(8'h20);
    tick(); tick(); tick();
    chk("R8 blocked req", req_o, 0);
    pri_i = 1'b1; #0.5;
    chk("R8 req", req_o, 1);
    ack_expect("R8 vector", 5);
    chk("R8 cleared", req_o, 0);

    // R9 edge coincides with ack
    pulse(8'h01);
    ack_i = 1'b1; irq_i = 8'h01; #0.5;
    chk("R9 vector", vec_o, vec_of(0));
    tick(); ack_i = 1'b0; irq_i = '0; #0.5;
    chk("R9 still pending", req_o, 1);
    ack_expect("R9 second vector", 0);
    chk("R9 cleared", req_o, 0);

    // R6 selective clear
    pulse(8'h81);
    ack_expect("R6 first", 0);
    chk("R6 other kept", req_o, 1);
    ack_expect("R6 second", 7);
    chk("R6 empty", req_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule